// File: doc/BRIEF.md
# Fixed-Latency Trigger Capture Buffer

This block sits behind a multichannel digitizer running at 40 MHz. On every clock it stores one 14-bit sample per channel into a circular history memory, so that a trigger arriving up to a programmed latency later can still reach back to the samples of interest. When a first-level trigger pulse arrives, the block reserves a slot in an on-chip event store and queues the trigger. A capture engine then copies a window of consecutive samples, starting a programmed number of cycles before the trigger, out of the history and into that slot. Each trigger gets an event number from a running 24-bit trigger counter.

Captured events wait in the store until a second-level request names their event number. The block then emits one header beat followed by the window samples of each channel that carries a signal. A channel whose samples all stay within a programmable threshold of that channel's pedestal is left out, unless the request asks for a full, unsuppressed readout. Once its last beat has been sent, a slot is free for new triggers.

Top module: `evt_capture_buf`

## Requirements
- R1: Every clock after reset release, the word on `sampleIn` is written into the history memory. The history holds the last HIST sample words.
- R2: A trigger seen at the clock edge that writes sample index n captures samples n-L through n-L+W-1, where L = `cfgLatency` and W = `cfgWinLen` (1..WMAX), both taken at trigger time. Valid configurations satisfy W <= L and L + NEV*(WMAX+1) < HIST.
- R3: Every trigger pulse, whether accepted or rejected, consumes the next event number. Numbering starts at 0 after reset. The event number appears in header bits [23:0].
- R4: A trigger that arrives while all NEV slots are reserved is dropped and increments `lostCount` by one. A slot freed by a completed readout accepts a later trigger.
- R5: Triggers on consecutive cycles are queued while a capture is in progress. Each one is captured with its own window, and requests may retrieve the events in any order.
- R6: An accepted request for a stored event produces a header beat (`outIsHeader`=1, bit 24 = 0, bits [25+c] = 1 when channel c is read out). The header is followed by data beats for the kept channels in ascending channel order, oldest sample first. A data beat carries the sample in bits [13:0] and the channel index in bits [16+:2]. The header appears in the cycle after the request edge.
- R7: A channel is suppressed when |sample - pedestal| <= `cfgThreshold` for every sample in its window. A difference exactly equal to the threshold counts as quiet, and differences below the pedestal count too.
- R8: A request with `reqFull`=1 reads out every channel, regardless of the samples.
- R9: A request for an event number that is not stored produces a single header beat with bit 24 = 1, a zero channel mask and the requested number in bits [23:0]. No data beats follow.
- R10: A request that arrives while a readout is in progress is ignored. It does not alter the running stream and does not release the event it names.
- R11: During and directly after reset, `outValid` is 0 and `lostCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | NCH*SW | One sample per channel, channel c at bits [c*SW +: SW] |
| trigIn | input | 1 | First-level trigger pulse |
| cfgLatency | input | log2(HIST) | Look-back distance in samples |
| cfgWinLen | input | log2(WMAX)+1 | Samples per captured window |
| cfgPedestal | input | NCH*SW | Per-channel pedestal value |
| cfgThreshold | input | SW | Quiet band half-width |
| reqIn | input | 1 | Second-level read request pulse |
| reqNum | input | 24 | Requested event number |
| reqFull | input | 1 | Bypass zero suppression for this request |
| outValid | output | 1 | Output beat valid |
| outIsHeader | output | 1 | Current beat is a header |
| outData | output | 25+NCH | Header or data beat |
| lostCount | output | LCW | Number of dropped triggers |

## Verification
The bench builds the block with four channels, four event slots, a 128-deep history and windows of up to 16 samples. With only four slots, a burst of five triggers on consecutive cycles already drives the store full and overfills the queue. This brings the lost-trigger path, the queued capture of back-to-back triggers and slot reuse within a few hundred cycles. Windows of 1 and 16 samples cover both ends of the length range. Per-channel offsets exercise suppression exactly at the threshold, one count above it, and on the low side of the pedestal.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  // strobes from control to datapath for one capture step
  typedef struct packed {
    logic capWe;     // write one window word into the event store
    logic capFirst;  // first word of a window: restart quiet tracking
  } capStrobe_t;

  typedef enum logic [1:0] {RD_IDLE, RD_HDR, RD_DATA} rdState_t;
endpackage

// File: rtl/tcap_dp.sv
module tcap_dp import tcap_pkg::*; #(
  parameter int NCH  = 4,
  parameter int NEV  = 4,
  parameter int HIST = 128,
  parameter int WMAX = 16,
  parameter int SW   = 14,
  localparam int HAW = $clog2(HIST),
  localparam int WIW = $clog2(WMAX),
  localparam int SLW = (NEV > 1) ? $clog2(NEV) : 1,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int EAW = $clog2(NEV * WMAX)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NCH*SW-1:0]   sampleIn,
  input  logic [HAW-1:0]      wrPtr,
  input  logic [HAW-1:0]      histRdAddr,
  input  capStrobe_t          strobe,
  input  logic [SLW-1:0]      capSlot,
  input  logic [WIW-1:0]      capIdx,
  input  logic [NCH*SW-1:0]   cfgPedestal,
  input  logic [SW-1:0]       cfgThreshold,
  input  logic [SLW-1:0]      rdSlot,
  input  logic [WIW-1:0]      rdIdx,
  input  logic [CHW-1:0]      rdCh,
  output logic [NEV*NCH-1:0]  quietFlags,
  output logic [SW-1:0]       rdSample
);
  logic [NCH*SW-1:0] histMem [HIST];
  logic [NCH*SW-1:0] evMem [NEV*WMAX];
  logic [NCH*SW-1:0] histWord;
  logic [NCH-1:0]    quietNow;
  logic [NEV*NCH-1:0] quietQ;
  logic [EAW-1:0]    capAddr, rdAddr;

  // continuous history write
  always_ff @(posedge clk) histMem[wrPtr] <= sampleIn;

  assign histWord = histMem[histRdAddr];
  assign capAddr  = EAW'(capSlot) * EAW'(WMAX) + EAW'(capIdx);
  assign rdAddr   = EAW'(rdSlot) * EAW'(WMAX) + EAW'(rdIdx);

  always_ff @(posedge clk)
    if (strobe.capWe) evMem[capAddr] <= histWord;

  // per-channel pedestal band test on the word being captured
  for (genvar c = 0; c < NCH; c++) begin : g_quiet
    logic signed [SW+1:0] diff, mag;
    always_comb begin
      diff = $signed({2'b00, histWord[c*SW +: SW]}) - $signed({2'b00, cfgPedestal[c*SW +: SW]});
      mag  = (diff < 0) ? -diff : diff;
    end
    assign quietNow[c] = (mag <= $signed({2'b00, cfgThreshold}));
  end

  always_ff @(posedge clk)
    if (strobe.capWe)
      for (int c = 0; c < NCH; c++)
        quietQ[int'(capSlot)*NCH + c] <= quietNow[c] & (strobe.capFirst | quietQ[int'(capSlot)*NCH + c]);

  assign quietFlags = quietQ;
  assign rdSample   = evMem[rdAddr][int'(rdCh)*SW +: SW];

  // R2: a capture never reads the history entry being overwritten in the same cycle
  p_cap_not_current_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capWe |-> histRdAddr != wrPtr);
endmodule

// File: rtl/tcap_ctrl.sv
module tcap_ctrl import tcap_pkg::*; #(
  parameter int NCH  = 4,
  parameter int NEV  = 4,
  parameter int HIST = 128,
  parameter int WMAX = 16,
  parameter int EVW  = 24,
  parameter int LCW  = 16,
  localparam int HAW  = $clog2(HIST),
  localparam int WIW  = $clog2(WMAX),
  localparam int SLW  = (NEV > 1) ? $clog2(NEV) : 1,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int QW   = $clog2(NEV + 1),
  localparam int OUTW = EVW + 1 + NCH
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigIn,
  input  logic [HAW-1:0]     cfgLatency,
  input  logic [WIW:0]       cfgWinLen,
  input  logic               reqIn,
  input  logic [EVW-1:0]     reqNum,
  input  logic               reqFull,
  input  logic [NEV*NCH-1:0] quietFlags,
  output capStrobe_t         strobe,
  output logic [HAW-1:0]     wrPtr,
  output logic [HAW-1:0]     histRdAddr,
  output logic [SLW-1:0]     capSlot,
  output logic [WIW-1:0]     capIdx,
  output logic [SLW-1:0]     rdSlot,
  output logic [WIW-1:0]     rdIdx,
  output logic [CHW-1:0]     rdCh,
  output logic               outValid,
  output logic               outIsHeader,
  output logic [OUTW-1:0]    hdrWord,
  output logic [LCW-1:0]     lostCount
);
  logic [HAW-1:0] wrPtrQ;
  logic [EVW-1:0] trigCount;
  logic [LCW-1:0] lostQ;
  logic [NEV-1:0] slotUsed, slotValid;
  logic [EVW-1:0] evNum   [NEV];
  logic [WIW:0]   slotWin [NEV];
  logic [HAW-1:0] fifoBase [NEV];
  logic [SLW-1:0] fifoSlot [NEV];
  logic [SLW-1:0] fWp, fRp;
  logic [QW-1:0]  fCnt;
  logic           capBusy;
  logic [SLW-1:0] capSlotQ;
  logic [HAW-1:0] capBaseQ;
  logic [WIW-1:0] capIdxQ;
  rdState_t       rdSt;
  logic [SLW-1:0] rdSlotQ;
  logic           rdHit, rdFullQ;
  logic [EVW-1:0] rdNumQ;
  logic [NCH-1:0] keepQ, keepNow;
  logic [CHW-1:0] rdChQ;
  logic [WIW-1:0] rdIdxQ;
  logic           freeFound, hitFound;
  logic [SLW-1:0] freeSlot, hitSlot;
  logic           accept, pop, capLast, curKeep, lastIdx, chDone, lastCh, relNow;

  function automatic logic [SLW-1:0] nextPtr(input logic [SLW-1:0] p);
    return (p == SLW'(NEV - 1)) ? '0 : p + 1'b1;
  endfunction

  // lowest free slot and matching stored slot
  always_comb begin
    freeFound = 1'b0; freeSlot = '0; hitFound = 1'b0; hitSlot = '0;
    for (int i = NEV - 1; i >= 0; i--) begin
      if (!slotUsed[i]) begin freeFound = 1'b1; freeSlot = SLW'(i); end
      if (slotValid[i] && evNum[i] == reqNum) begin hitFound = 1'b1; hitSlot = SLW'(i); end
    end
  end

  assign accept  = trigIn && freeFound;
  assign pop     = !capBusy && (fCnt != '0);
  assign capLast = capBusy && ({1'b0, capIdxQ} == slotWin[capSlotQ] - 1'b1);
  assign keepNow = rdFullQ ? {NCH{1'b1}} : ~quietFlags[int'(rdSlotQ)*NCH +: NCH];
  assign curKeep = keepQ[rdChQ];
  assign lastIdx = ({1'b0, rdIdxQ} == slotWin[rdSlotQ] - 1'b1);
  assign chDone  = !curKeep || lastIdx;
  assign lastCh  = (rdChQ == CHW'(NCH - 1));
  assign relNow  = (rdSt == RD_DATA) && chDone && lastCh;

  // tables without reset: only read where a valid/used bit qualifies them
  always_ff @(posedge clk)
    if (accept) begin
      fifoBase[fWp]     <= wrPtrQ - cfgLatency;
      fifoSlot[fWp]     <= freeSlot;
      evNum[freeSlot]   <= trigCount;
      slotWin[freeSlot] <= cfgWinLen;
    end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtrQ <= '0; trigCount <= '0; lostQ <= '0;
      slotUsed <= '0; slotValid <= '0;
      fWp <= '0; fRp <= '0; fCnt <= '0;
      capBusy <= 1'b0; capSlotQ <= '0; capBaseQ <= '0; capIdxQ <= '0;
      rdSt <= RD_IDLE; rdSlotQ <= '0; rdHit <= 1'b0; rdFullQ <= 1'b0;
      rdNumQ <= '0; keepQ <= '0; rdChQ <= '0; rdIdxQ <= '0;
    end else begin
      wrPtrQ <= wrPtrQ + 1'b1;
      if (trigIn) begin
        trigCount <= trigCount + 1'b1;
        if (!freeFound) lostQ <= lostQ + 1'b1;
      end
      // trigger queue
      if (accept) fWp <= nextPtr(fWp);
      if (pop)    fRp <= nextPtr(fRp);
      if (accept && !pop)      fCnt <= fCnt + 1'b1;
      else if (!accept && pop) fCnt <= fCnt - 1'b1;
      // slot bookkeeping
      for (int i = 0; i < NEV; i++) begin
        if (accept && freeSlot == SLW'(i))            slotUsed[i]  <= 1'b1;
        else if (relNow && rdSlotQ == SLW'(i))        slotUsed[i]  <= 1'b0;
        if (capLast && capSlotQ == SLW'(i))           slotValid[i] <= 1'b1;
        else if (relNow && rdSlotQ == SLW'(i))        slotValid[i] <= 1'b0;
      end
      // capture engine
      if (pop) begin
        capBusy  <= 1'b1;
        capSlotQ <= fifoSlot[fRp];
        capBaseQ <= fifoBase[fRp];
        capIdxQ  <= '0;
      end else if (capBusy) begin
        capIdxQ <= capIdxQ + 1'b1;
        if (capLast) capBusy <= 1'b0;
      end
      // readout engine
      unique case (rdSt)
        RD_IDLE: if (reqIn) begin
          rdSt <= RD_HDR; rdHit <= hitFound; rdSlotQ <= hitSlot;
          rdFullQ <= reqFull; rdNumQ <= reqNum;
        end
        RD_HDR: begin
          rdSt   <= rdHit ? RD_DATA : RD_IDLE;
          keepQ  <= keepNow;
          rdChQ  <= '0;
          rdIdxQ <= '0;
        end
        RD_DATA: begin
          if (chDone) begin
            rdIdxQ <= '0;
            if (lastCh) rdSt <= RD_IDLE;
            else        rdChQ <= rdChQ + 1'b1;
          end else begin
            rdIdxQ <= rdIdxQ + 1'b1;
          end
        end
        default: rdSt <= RD_IDLE;
      endcase
    end
  end

  assign strobe.capWe    = capBusy;
  assign strobe.capFirst = capBusy && (capIdxQ == '0);
  assign wrPtr       = wrPtrQ;
  assign histRdAddr  = capBaseQ + HAW'(capIdxQ);
  assign capSlot     = capSlotQ;
  assign capIdx      = capIdxQ;
  assign rdSlot      = rdSlotQ;
  assign rdIdx       = rdIdxQ;
  assign rdCh        = rdChQ;
  assign outIsHeader = (rdSt == RD_HDR);
  assign outValid    = (rdSt == RD_HDR) || ((rdSt == RD_DATA) && curKeep);
  assign hdrWord     = {rdHit ? keepNow : {NCH{1'b0}}, !rdHit, rdNumQ};
  assign lostCount   = lostQ;

  // R4: a trigger meeting a full store is counted as lost
  p_lost_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (trigIn && (&slotUsed)) |=> lostQ == $past(lostQ) + LCW'(1));
  // R5: the pending-trigger queue never holds more than the slots it reserves
  p_queue_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    fCnt <= QW'(NEV));
  // R2: capture index stays inside the window of its slot
  p_cap_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    capBusy |-> ({1'b0, capIdxQ} < slotWin[capSlotQ]));
  // R6: an accepted request yields a header in the next cycle
  p_hdr_follows_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdSt == RD_IDLE && reqIn) |=> (outValid && outIsHeader));
  // R9: an empty header is a complete response
  p_empty_alone_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outIsHeader && !rdHit) |=> !outValid);
  // R10: a request during a data stream starts no new header
  p_busy_ignores_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdSt == RD_DATA && !relNow && reqIn) |=> !outIsHeader);
endmodule

// File: rtl/evt_capture_buf.sv
module evt_capture_buf import tcap_pkg::*; #(
  parameter int NCH  = 4,
  parameter int NEV  = 4,
  parameter int HIST = 128,
  parameter int WMAX = 16,
  parameter int SW   = 14,
  parameter int EVW  = 24,
  parameter int LCW  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NCH*SW-1:0]         sampleIn,
  input  logic                      trigIn,
  input  logic [$clog2(HIST)-1:0]   cfgLatency,
  input  logic [$clog2(WMAX):0]     cfgWinLen,
  input  logic [NCH*SW-1:0]         cfgPedestal,
  input  logic [SW-1:0]             cfgThreshold,
  input  logic                      reqIn,
  input  logic [EVW-1:0]            reqNum,
  input  logic                      reqFull,
  output logic                      outValid,
  output logic                      outIsHeader,
  output logic [EVW+NCH:0]          outData,
  output logic [LCW-1:0]            lostCount
);
  localparam int HAW  = $clog2(HIST);
  localparam int WIW  = $clog2(WMAX);
  localparam int SLW  = (NEV > 1) ? $clog2(NEV) : 1;
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int OUTW = EVW + 1 + NCH;

  capStrobe_t         strobe;
  logic [HAW-1:0]     wrPtr, histRdAddr;
  logic [SLW-1:0]     capSlot, rdSlot;
  logic [WIW-1:0]     capIdx, rdIdx;
  logic [CHW-1:0]     rdCh;
  logic [NEV*NCH-1:0] quietFlags;
  logic [SW-1:0]      rdSample;
  logic [OUTW-1:0]    hdrWord;

  tcap_ctrl #(.NCH(NCH), .NEV(NEV), .HIST(HIST), .WMAX(WMAX), .EVW(EVW), .LCW(LCW)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .cfgLatency(cfgLatency), .cfgWinLen(cfgWinLen),
    .reqIn(reqIn), .reqNum(reqNum), .reqFull(reqFull), .quietFlags(quietFlags),
    .strobe(strobe), .wrPtr(wrPtr), .histRdAddr(histRdAddr), .capSlot(capSlot), .capIdx(capIdx),
    .rdSlot(rdSlot), .rdIdx(rdIdx), .rdCh(rdCh), .outValid(outValid), .outIsHeader(outIsHeader),
    .hdrWord(hdrWord), .lostCount(lostCount));

  tcap_dp #(.NCH(NCH), .NEV(NEV), .HIST(HIST), .WMAX(WMAX), .SW(SW)) u_dp (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .wrPtr(wrPtr), .histRdAddr(histRdAddr),
    .strobe(strobe), .capSlot(capSlot), .capIdx(capIdx), .cfgPedestal(cfgPedestal),
    .cfgThreshold(cfgThreshold), .rdSlot(rdSlot), .rdIdx(rdIdx), .rdCh(rdCh),
    .quietFlags(quietFlags), .rdSample(rdSample));

  assign outData = outIsHeader ? hdrWord : OUTW'({rdCh, 2'b00, rdSample});
endmodule

// File: tb/sim_evt_capture_buf.sv
module sim_evt_capture_buf;
  localparam int NCH = 4, NEV = 4, HIST = 128, WMAX = 16, SW = 14, EVW = 24, LCW = 16;
  localparam int HAW = $clog2(HIST), WIW = $clog2(WMAX), OUTW = EVW + 1 + NCH;

  logic clk = 1'b0, rstN = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [NCH*SW-1:0] sampleIn = '0;
  logic trigIn = 1'b0, reqIn = 1'b0, reqFull = 1'b0;
  logic [EVW-1:0] reqNum = '0;
  int lat = 10, win = 4, thr = 3;
  int ped [NCH] = '{1000, 2000, 50, 16000};
  int dev [NCH] = '{0, 0, 0, 0};
  logic [HAW-1:0] cfgLatency;
  logic [WIW:0] cfgWinLen;
  logic [NCH*SW-1:0] cfgPedestal;
  logic [SW-1:0] cfgThreshold;
  logic outValid, outIsHeader;
  logic [OUTW-1:0] outData;
  logic [LCW-1:0] lostCount;

  assign cfgLatency   = HAW'(lat);
  assign cfgWinLen    = (WIW+1)'(win);
  assign cfgThreshold = SW'(thr);
  always_comb for (int c = 0; c < NCH; c++) cfgPedestal[c*SW +: SW] = SW'(ped[c]);

  evt_capture_buf #(.NCH(NCH), .NEV(NEV), .HIST(HIST), .WMAX(WMAX), .SW(SW), .EVW(EVW), .LCW(LCW)) u0 (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .trigIn(trigIn), .cfgLatency(cfgLatency),
    .cfgWinLen(cfgWinLen), .cfgPedestal(cfgPedestal), .cfgThreshold(cfgThreshold),
    .reqIn(reqIn), .reqNum(reqNum), .reqFull(reqFull), .outValid(outValid),
    .outIsHeader(outIsHeader), .outData(outData), .lostCount(lostCount));

  int checks = 0, fails = 0, wd = 0, cyc = 0, trigCnt = 0, lostExp = 0;
  logic [NCH*SW-1:0] sampLog [int];
  int mNum [$], mStart [$], mWin [$];
  logic [OUTW-1:0] expQ [$];
  logic hdrQ [$];
  string tagQ [$];
  logic [OUTW-1:0] eW;
  logic eH;
  string eT;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: got %0d expected %0d", tag, got, exp); end
  endtask

  // sample index counter: index of the sample written at the next rising edge
  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  // stimulus samples: pedestal + per-channel offset + wobble in -1..+1
  always @(negedge clk) begin
    logic [NCH*SW-1:0] w;
    for (int c = 0; c < NCH; c++) w[c*SW +: SW] = SW'(ped[c] + dev[c] + ((cyc + c) % 3) - 1);
    sampleIn = w;
    sampLog[cyc] = w;
  end

  function automatic int sampAt(input int idx, input int c);
    return int'(sampLog[idx][c*SW +: SW]);
  endfunction

  // output monitor compared against the reference stream every cycle
  always @(negedge clk) begin
    if (rstN && outValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++; $display("FAIL R6 unexpected beat: got %h expected none", outData);
      end else begin
        eW = expQ.pop_front(); eH = hdrQ.pop_front(); eT = tagQ.pop_front();
        if (outData !== eW || outIsHeader !== eH) begin
          fails++; $display("FAIL %s: got %0b/%h expected %0b/%h", eT, outIsHeader, outData, eH, eW);
        end
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++; $display("FAIL watchdog: got %0d cycles expected fewer", wd);
      summary(); $finish;
    end
  end

  task automatic doTrigs(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      trigIn = 1'b1;
      if (mNum.size() < NEV) begin   // R3, R4: model of numbering and slot limit
        mNum.push_back(trigCnt); mStart.push_back(cyc - lat); mWin.push_back(win);
      end else lostExp++;
      trigCnt++;
    end
    @(negedge clk); trigIn = 1'b0;
  endtask

  task automatic doReq(input int num, input bit full);
    int k;
    logic [OUTW-1:0] h;
    logic [NCH-1:0] mask;
    k = -1;
    @(negedge clk);
    reqIn = 1'b1; reqNum = EVW'(num); reqFull = full;
    foreach (mNum[i]) if (mNum[i] == num) k = i;
    h = '0; h[EVW-1:0] = EVW'(num);
    if (k < 0) begin
      h[EVW] = 1'b1;
      expQ.push_back(h); hdrQ.push_back(1'b1); tagQ.push_back("R9 empty header");
    end else begin
      for (int c = 0; c < NCH; c++) begin
        mask[c] = full;
        for (int i = 0; i < mWin[k]; i++) begin
          int d;
          d = sampAt(mStart[k] + i, c) - ped[c];
          if (d > thr || d < -thr) mask[c] = 1'b1;
        end
      end
      h[EVW+1 +: NCH] = mask;
      expQ.push_back(h); hdrQ.push_back(1'b1);
      tagQ.push_back(full ? "R8 full header" : "R3/R7 header");
      for (int c = 0; c < NCH; c++)
        if (mask[c])
          for (int i = 0; i < mWin[k]; i++) begin
            expQ.push_back((OUTW'(c) << (SW + 2)) | OUTW'(sampAt(mStart[k] + i, c)));
            hdrQ.push_back(1'b0); tagQ.push_back("R1/R2/R6 sample");
          end
      mNum.delete(k); mStart.delete(k); mWin.delete(k);
    end
    @(negedge clk); reqIn = 1'b0; reqFull = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R11 outValid in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R11 outValid after reset", int'(outValid), 0);
    chk(lostCount == '0, "R11 lostCount after reset", int'(lostCount), 0);
    repeat (80) @(negedge clk);

    // R7: ch1 loud, ch2 exactly at threshold (quiet), ch3 below pedestal (kept)
    lat = 10; win = 4; dev = '{0, 20, 2, -3};
    doTrigs(1); repeat (40) @(negedge clk);
    doReq(0, 1'b0); drain();
    // R8: full readout of an otherwise suppressed set
    doTrigs(1); repeat (40) @(negedge clk);
    doReq(1, 1'b1); drain();
    // R9: unknown number
    doReq(77, 1'b0); drain();

    // R5, R4: five triggers back to back into four slots
    lat = 30; win = 16; dev = '{5, 0, 0, 0};
    doTrigs(5); repeat (100) @(negedge clk);
    chk(lostCount == LCW'(lostExp), "R4 lost count after burst", int'(lostCount), lostExp);
    doReq(4, 1'b0); drain();
    // R10: second request during a running readout is ignored
    doReq(2, 1'b0);
    repeat (4) @(negedge clk);
    @(negedge clk); reqIn = 1'b1; reqNum = EVW'(3);
    @(negedge clk); reqIn = 1'b0;
    drain();
    doReq(3, 1'b0); drain();   // R10: event 3 still stored
    doReq(5, 1'b0); drain();
    doReq(6, 1'b0); drain();   // R4: dropped event reads as empty

    // R4 slot reuse, R2 shortest window at shortest latency
    lat = 1; win = 1; dev = '{0, 0, 0, 9};
    doTrigs(1); repeat (20) @(negedge clk);
    chk(lostCount == LCW'(lostExp), "R4 lost count after reuse", int'(lostCount), lostExp);
    doReq(7, 1'b0); drain();

    chk(expQ.size() == 0, "R6 all expected beats seen", expQ.size(), 0);
    summary();
    $finish;
  end
endmodule